// File: doc/BRIEF.md
# Instruction Index Modification and Operand Address Decode

This block sits between instruction fetch and execute. It accepts one 20-bit instruction word at a time, along with the current instruction location and the two modifier registers. It splits the word into its fields and adds a modifier to the 10-bit address field. The index field chooses that modifier. The block then works out what the modified value means from the function group and the store-mode bit: a small immediate operand, a main store address, a fast store address, or a main store address read indirectly out of the fast store. For the indirect case it issues one read on a request/response port to the fast store and returns the word that comes back.

Instructions enter on a valid/ready stream. A result leaves on a second valid/ready stream. Back-pressure rules:
- `in_ready` is high only while the block is idle, so a new word is taken only after the previous result has been handed over.
- Once `out_valid` rises, it stays high with a stable payload until `out_ready` is seen high at a clock edge.
- The fast store request behaves the same way: `fs_req_valid` and `fs_req_addr` hold until `fs_req_ready`.
- The fast store response is a single-cycle `fs_rsp_valid` pulse. It may arrive no earlier than the cycle after the request was accepted.

The block also drives a level interrupt-inhibit output.

Top module: `instr_mod_decode`

## Requirements
- R1: The instruction word is split as follows:
  - bit 19 is the inhibit flag S
  - bit 18 is the store mode M
  - bits 17:12 are the function F, and `out_func` returns F unchanged
  - bits 11:10 are the index selector K
  - bits 9:0 are the address N
- R2: The effective value is N, zero-extended to 20 bits, plus the modifier, wrapping modulo 2^20. The modifier depends on K:
  - K=0 adds nothing
  - K=1 adds `mod_b`
  - K=2 adds the sequence modifier
  - K=3 adds `mod_r`
- R3: The sequence modifier is `cur_loc[18:0] + 1`, so bit 19 of `cur_loc` (the store-select flag) has no effect on the sum. `out_store_sel` returns that flag unchanged.
- R4: In function groups 0 and 1 (F[5:3]), with M=0, the result has `out_mode`=0 (immediate) and `out_value` equal to the effective value.
- R5: In groups 0 and 1 with M=1, `out_mode`=1 (main store address) and `out_value` is the effective value.
- R6: In groups 2 and 3 with M=0, `out_mode`=2 (fast store address) and `out_value` is the effective value.
- R7: In groups 2 and 3 with M=1, the block issues exactly one fast store read at address bits 9:0 of the effective value. The result then has `out_mode`=3 (indirect) and `out_value` equal to the returned word. No other case issues a read.
- R8: In groups 4 to 7, `out_mode`=4 (other) and `out_value` is the effective value, whatever M is.
- R9: After an instruction is accepted, `in_ready` stays low until its result has been taken. After reset, `in_ready` is high and `out_valid` is low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_value`, `out_mode` and `out_func` hold.
- R11: `out_inhibit` is low after reset. At each result hand-over it takes that instruction's S bit and holds it until the next hand-over. An inhibiting instruction therefore keeps interrupts off until its successor has completed.
- R12: While `fs_req_valid` is high and `fs_req_ready` is low, the request and its address hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to take an instruction |
| in_instr | input | 20 | Instruction word |
| cur_loc | input | 20 | Current instruction location, bit 19 store-select |
| mod_b | input | 20 | Modifier register |
| mod_r | input | 20 | Auxiliary register |
| fs_req_valid | output | 1 | Fast store read request |
| fs_req_ready | input | 1 | Fast store accepts request |
| fs_req_addr | output | 10 | Fast store read address |
| fs_rsp_valid | input | 1 | Fast store read data valid (one cycle) |
| fs_rsp_data | input | 20 | Fast store read data |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_mode | output | 3 | 0 immediate, 1 main, 2 fast, 3 indirect, 4 other |
| out_value | output | 20 | Operand or address |
| out_func | output | 6 | Function field of the instruction |
| out_store_sel | output | 1 | Store-select flag of the location, passed through |
| out_inhibit | output | 1 | Interrupt inhibit level |

## Verification
A wrong index selection, a store-select bit leaking into the sum, or a lost carry shows up in `out_value` of that same instruction, on the first cycle `out_valid` is high. A wrong group or mode decision shows in `out_mode` at that same point. For the indirect case, it also shows as an unexpected request or a missing one before the result appears. A corrupted control state shows within a cycle or two in one of three ways: `in_ready` rising while a result is pending, payload changing under back-pressure, or the inhibit level moving outside a hand-over. The bench compares every cycle, so each fault is pinned to the cycle it first appears.

// File: rtl/imd_pkg.sv
package imd_pkg;
  localparam int WORD_W = 20;
  localparam int ADDR_W = 10;
  localparam int FUNC_W = 6;
  localparam int IDX_W  = 2;

  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_MAIN  = 3'd1,
    AM_FAST  = 3'd2,
    AM_IND   = 3'd3,
    AM_OTHER = 3'd4
  } amode_e;

  typedef enum logic [IDX_W-1:0] {
    IX_NONE = 2'd0,
    IX_B    = 2'd1,
    IX_SEQ  = 2'd2,
    IX_R    = 2'd3
  } idx_e;

  typedef struct packed {
    logic              inh;
    logic              smode;
    logic [FUNC_W-1:0] func;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
  } instr_t;
endpackage

// File: rtl/index_modifier.sv
module index_modifier
  import imd_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NW = ADDR_W
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [NW-1:0]    n_field,
  input  logic [W-1:0]     mod_b,
  input  logic [W-1:0]     mod_r,
  input  logic [W-2:0]     loc_body,
  output logic [W-1:0]     eff
);
  localparam int PAD = W - NW;

  logic [W-1:0] seq_mod;
  logic [W-1:0] chosen;

  // next-instruction address with the store-select flag stripped
  assign seq_mod = {1'b0, loc_body} + W'(1);

  always_comb begin
    unique case (idx_e'(idx))
      IX_NONE: chosen = '0;
      IX_B:    chosen = mod_b;
      IX_SEQ:  chosen = seq_mod;
      IX_R:    chosen = mod_r;
      default: chosen = '0;
    endcase
  end

  assign eff = {{PAD{1'b0}}, n_field} + chosen;
endmodule

// File: rtl/group_decode.sv
module group_decode
  import imd_pkg::*;
#(
  parameter int FW = FUNC_W
) (
  input  logic [FW-1:0] func,
  input  logic          smode,
  output amode_e        mode
);
  localparam int GW = 3;

  logic [GW-1:0] grp;
  assign grp = func[FW-1 -: GW];

  always_comb begin
    case (grp)
      3'd0, 3'd1: mode = smode ? AM_MAIN : AM_IMM;
      3'd2, 3'd3: mode = smode ? AM_IND  : AM_FAST;
      default:    mode = AM_OTHER;
    endcase
  end
endmodule

// File: rtl/indirect_seq.sv
module indirect_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic need_ind,
  input  logic fs_req_ready,
  input  logic fs_rsp_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic accept,
  output logic fs_req_valid,
  output logic rsp_take,
  output logic out_valid
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d         = st_q;
    in_ready     = 1'b0;
    fs_req_valid = 1'b0;
    rsp_take     = 1'b0;
    out_valid    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) st_d = need_ind ? ST_REQ : ST_OUT;
      end
      ST_REQ: begin
        fs_req_valid = 1'b1;
        if (fs_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (fs_rsp_valid) begin
          rsp_take = 1'b1;
          st_d     = ST_OUT;
        end
      end
      ST_OUT: begin
        out_valid = 1'b1;
        if (out_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r9_free_after_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);
  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_req_valid && !fs_req_ready) |=> fs_req_valid);
endmodule

// File: rtl/instr_mod_decode.sv
module instr_mod_decode
  import imd_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NW = ADDR_W,
  parameter int FW = FUNC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_instr,
  input  logic [W-1:0]  cur_loc,
  input  logic [W-1:0]  mod_b,
  input  logic [W-1:0]  mod_r,
  output logic          fs_req_valid,
  input  logic          fs_req_ready,
  output logic [NW-1:0] fs_req_addr,
  input  logic          fs_rsp_valid,
  input  logic [W-1:0]  fs_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_mode,
  output logic [W-1:0]  out_value,
  output logic [FW-1:0] out_func,
  output logic          out_store_sel,
  output logic          out_inhibit
);
  instr_t       ins;
  logic [W-1:0] eff;
  amode_e       mode_d;
  logic         accept, rsp_take, need_ind;

  assign ins = instr_t'(in_instr);

  index_modifier #(.W(W), .NW(NW)) u_mod (
    .idx      (ins.idx),
    .n_field  (ins.addr),
    .mod_b    (mod_b),
    .mod_r    (mod_r),
    .loc_body (cur_loc[W-2:0]),
    .eff      (eff)
  );

  group_decode #(.FW(FW)) u_dec (
    .func  (ins.func),
    .smode (ins.smode),
    .mode  (mode_d)
  );

  assign need_ind = (mode_d == AM_IND);

  indirect_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .need_ind     (need_ind),
    .fs_req_ready (fs_req_ready),
    .fs_rsp_valid (fs_rsp_valid),
    .out_ready    (out_ready),
    .in_ready     (in_ready),
    .accept       (accept),
    .fs_req_valid (fs_req_valid),
    .rsp_take     (rsp_take),
    .out_valid    (out_valid)
  );

  logic [W-1:0]  val_q;
  amode_e        mode_q;
  logic [FW-1:0] func_q;
  logic          inh_q, ss_q, inhibit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      mode_q <= AM_IMM;
      func_q <= '0;
      inh_q  <= 1'b0;
      ss_q   <= 1'b0;
    end else if (accept) begin
      val_q  <= eff;
      mode_q <= mode_d;
      func_q <= ins.func;
      inh_q  <= ins.inh;
      ss_q   <= cur_loc[W-1];
    end else if (rsp_take) begin
      val_q  <= fs_rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      inhibit_q <= 1'b0;
    else if (out_valid && out_ready) inhibit_q <= inh_q;
  end

  assign fs_req_addr   = val_q[NW-1:0];
  assign out_value     = val_q;
  assign out_mode      = mode_q;
  assign out_func      = func_q;
  assign out_store_sel = ss_q;
  assign out_inhibit   = inhibit_q;

  a_r10_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_value) && $stable(out_mode) && $stable(out_func)));
  a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_req_valid && !fs_req_ready) |=> $stable(fs_req_addr));
  a_r7_req_only_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    fs_req_valid |-> (out_mode == 3'd3));
  a_r11_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> $stable(out_inhibit));
endmodule

// File: tb/instr_mod_decode_tb.sv
module instr_mod_decode_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [19:0] in_instr = '0, cur_loc = '0, mod_b = '0, mod_r = '0;
  logic        fs_req_valid, fs_req_ready = 1'b0;
  logic [9:0]  fs_req_addr;
  logic        fs_rsp_valid = 1'b0;
  logic [19:0] fs_rsp_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [2:0]  out_mode;
  logic [19:0] out_value;
  logic [5:0]  out_func;
  logic        out_store_sel, out_inhibit;

  instr_mod_decode dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0, running = 1'b0;

  int q_mode[$], q_val[$], q_func[$], q_s[$], q_ss[$], q_faddr[$];
  int n_ind_exp = 0, n_req = 0, rsp_cnt = 0, rsp_addr = 0;
  int inh_model = 0, inh_next = 0;
  bit prev_hold = 0, prev_req_hold = 0;
  int prev_val, prev_mode, prev_func, prev_raddr;

  function automatic int fs_word(int a);
    return (a * 40503 + 777) & 20'hFFFFF;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference for one instruction
  task automatic expect_instr(int ins, int loc, int b, int r);
    int s, m, f, k, n, grp, modv, eff, mode;
    s = (ins >> 19) & 1; m = (ins >> 18) & 1; f = (ins >> 12) & 63;
    k = (ins >> 10) & 3; n = ins & 1023; grp = f / 8;
    if (k == 0) modv = 0;
    else if (k == 1) modv = b;
    else if (k == 2) modv = (loc % 524288) + 1;
    else modv = r;
    eff = (n + modv) % 1048576;
    if (grp < 2) mode = m ? 1 : 0;
    else if (grp < 4) mode = m ? 3 : 2;
    else mode = 4;
    q_mode.push_back(mode);
    q_val.push_back(mode == 3 ? fs_word(eff % 1024) : eff);
    q_faddr.push_back(eff % 1024);
    q_func.push_back(f); q_s.push_back(s); q_ss.push_back(loc / 524288);
    if (mode == 3) n_ind_exp++;
  endtask

  task automatic send(int ins, int loc, int b, int r);
    bit acc;
    @(negedge clk);
    in_instr = 20'(ins); cur_loc = 20'(loc); mod_b = 20'(b); mod_r = 20'(r);
    in_valid = 1'b1;
    forever begin
      acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    expect_instr(ins, loc, b, r);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int mk(int s, int m, int f, int k, int n);
    return (s << 19) | (m << 18) | (f << 12) | (k << 10) | n;
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (running) begin
      cyc++;
      inh_model = inh_next;
      chk(out_inhibit == inh_model[0], "R11", out_inhibit, inh_model);
      if (out_valid) chk(!in_ready, "R9", in_ready, 0);
      if (prev_hold) begin
        chk(out_valid && out_value == prev_val[19:0], "R10", out_value, prev_val);
        chk(out_mode == prev_mode[2:0] && out_func == prev_func[5:0], "R10", out_mode, prev_mode);
      end
      if (prev_req_hold)
        chk(fs_req_valid && fs_req_addr == prev_raddr[9:0], "R12", fs_req_addr, prev_raddr);
      // fast store responder
      fs_rsp_valid = 1'b0;
      if (rsp_cnt == 1) begin
        fs_rsp_valid = 1'b1;
        fs_rsp_data = 20'(fs_word(rsp_addr));
      end
      if (rsp_cnt > 0) rsp_cnt--;
      fs_req_ready = (cyc % 4) != 1;
      if (fs_req_valid) begin
        chk(q_faddr.size() > 0 && q_mode[0] == 3, "R7", out_mode, 3);
        if (q_faddr.size() > 0)
          chk(fs_req_addr == q_faddr[0][9:0], "R7", fs_req_addr, q_faddr[0]);
      end
      if (fs_req_valid && fs_req_ready) begin
        n_req++; rsp_addr = fs_req_addr; rsp_cnt = 1 + (n_req % 3);
      end
      prev_req_hold = fs_req_valid && !fs_req_ready;
      prev_raddr = fs_req_addr;
      // result consumer
      out_ready = (cyc % 5) != 2;
      if (out_valid && out_ready) begin
        if (q_mode.size() == 0) chk(0, "R9", 1, 0);
        else begin
          case (q_mode[0])
            0: chk(out_mode == 0 && out_value == q_val[0][19:0], "R4", out_value, q_val[0]);
            1: chk(out_mode == 1 && out_value == q_val[0][19:0], "R5", out_value, q_val[0]);
            2: chk(out_mode == 2 && out_value == q_val[0][19:0], "R6", out_value, q_val[0]);
            3: chk(out_mode == 3 && out_value == q_val[0][19:0], "R7", out_value, q_val[0]);
            default: chk(out_mode == 4 && out_value == q_val[0][19:0], "R8", out_value, q_val[0]);
          endcase
          chk(out_mode == q_mode[0][2:0], "R2", out_mode, q_mode[0]);
          chk(out_func == q_func[0][5:0], "R1", out_func, q_func[0]);
          chk(out_store_sel == q_ss[0][0], "R3", out_store_sel, q_ss[0]);
          inh_next = q_s[0];
          void'(q_mode.pop_front()); void'(q_val.pop_front()); void'(q_func.pop_front());
          void'(q_s.pop_front()); void'(q_ss.pop_front()); void'(q_faddr.pop_front());
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_val = out_value; prev_mode = out_mode; prev_func = out_func;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state (R9, R11)
    chk(in_ready && !out_valid && !fs_req_valid, "R9", {in_ready, out_valid}, 2);
    chk(!out_inhibit, "R11", out_inhibit, 0);
    running = 1'b1;
    // R4 immediate, no modification
    send(mk(0, 0, 8'o05, 0, 1023), 100, 7, 9);
    // R2 B modifier with wrap past 2^20
    send(mk(0, 1, 8'o12, 1, 5), 0, 20'hFFFFF, 0);
    // R3 sequence modifier: store-select bit set, must not enter the sum
    send(mk(1, 1, 8'o01, 2, 3), 20'h80064, 0, 0);
    // R11 inhibit follows into next
    send(mk(0, 0, 8'o23, 3, 10), 0, 0, 20'h00400);
    // R6 fast store, R3 with body all ones (wraps to 0x80000)
    send(mk(0, 0, 8'o20, 2, 0), 20'hFFFFF, 0, 0);
    // R7 indirect, modified by B
    send(mk(1, 1, 8'o31, 1, 17), 0, 20'h00200, 0);
    send(mk(1, 1, 8'o37, 0, 1023), 0, 0, 0);
    // R8 other groups with both M values
    send(mk(0, 1, 8'o47, 1, 4), 0, 20'h12345, 0);
    send(mk(0, 0, 8'o77, 3, 1), 0, 0, 20'hFFFFF);
    // R1 field separation: all bits set
    send(20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF);
    for (int i = 0; i < 300; i++)
      send(int'($urandom) & 20'hFFFFF, int'($urandom) & 20'hFFFFF,
           int'($urandom) & 20'hFFFFF, int'($urandom) & 20'hFFFFF);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(q_mode.size() == 0, "R9", q_mode.size(), 0);
    chk(n_req == n_ind_exp, "R7", n_req, n_ind_exp);
    finish_run();
  end
endmodule